// File: doc/BRIEF.md
# Set-Associative Cache Lookup with Least-Recently-Used Replacement

This block holds the tags, valid flags, data words and recency state for a small set-associative cache. The low bits of a word address select one set. The remaining bits form a tag that is compared against every way of that set at the same time. The compare result, the matching way and the stored word appear combinationally on the same cycle as the request.

On a read miss, the requester holds the request and presents one word from backing memory with a fill strobe. The word is installed at the edge that ends that cycle. Writes are write-through: every write is forwarded to memory on the same cycle, and the cached copy is updated or allocated, so no line ever needs to be written back.

Replacement follows an exact recency order in each set. Every way carries an age, and the ages of a set are always a permutation of 0 to WAYS-1, where 0 means most recent. A way that is touched becomes age 0, and every way that was younger than it ages by one. When the set has an empty way, the lowest-numbered empty way is filled first. Otherwise the way of age WAYS-1 is replaced.

Top module: `sa_cache_lru`

## Requirements
- R1: After reset no way of any set is valid: every request misses and `victim_way` reads 0 in every set.
- R2: A request hits when a valid way of its set holds its tag. `hit_way` then names that way and `rd_data` carries that way's word. On a miss `rd_data` is 0.
- R3: The set is `req_addr[IDX_W-1:0]` and the tag is the remaining upper bits. Lines in different sets never affect one another, even when their tags are equal.
- R4: A read miss with `fill_valid` high installs `fill_data` and the request's tag at `victim_way`. From the next cycle on, that address hits with that word.
- R5: While a set has an invalid way, `victim_way` is the lowest-numbered invalid way.
- R6: When every way of the set is valid, `victim_way` is the way whose last hit, write or fill lies furthest in the past.
- R7: A read hit, a write, or a fill makes the touched way the most recent one, and the other ways of the set keep their relative order.
- R8: A write hit replaces the cached word with `req_wdata`. In the same cycle, `mem_wr` is 1 with `mem_wr_addr`=`req_addr` and `mem_wr_data`=`req_wdata`.
- R9: A write miss allocates `victim_way` with the request's tag and `req_wdata`. It raises `mem_wr` in the same way as R8.
- R10: A read never raises `mem_wr`. `fill_valid` has no effect on a read hit. A read miss without `fill_valid` leaves all cache state unchanged.
- R11: The ages of each set always form a permutation of 0 to WAYS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | ADDR_W | Word address: set in the low IDX_W bits, tag above them |
| req_wdata | input | DATA_W | Write data |
| fill_valid | input | 1 | Refill word for a held read miss is present |
| fill_data | input | DATA_W | Refill word |
| hit | output | 1 | Tag match in a valid way of the selected set |
| hit_way | output | WAY_W | Matching way |
| rd_data | output | DATA_W | Word of the matching way, 0 on a miss |
| victim_way | output | WAY_W | Way a miss in the selected set would replace |
| mem_wr | output | 1 | Write-through strobe to backing memory |
| mem_wr_addr | output | ADDR_W | Write-through address |
| mem_wr_data | output | DATA_W | Write-through data |

## Verification
The bench fills every set through its empty ways. It then drives a long pseudo-random stream of reads, writes, fills and fill-less misses. The addresses use five tags per set, so a three-way set must evict again and again. A reference model built from the requirements predicts hit, way, data and victim for every request.

Several faults would show up in this stream. A design that refilled an empty way other than the lowest would miss on the wrong way. A design that reset all ages on a touch, rather than shifting only the younger ones, would evict a recently used line and turn an expected hit into a miss. A design that honoured a fill strobe during a hit would overwrite live data. Aliasing across sets would let a line in one set satisfy a request to another.

// File: rtl/sa_cache_pkg.sv
package sa_cache_pkg;
    // Kind of state change a request causes at the next edge
    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_TOUCH = 2'd1,
        ACC_STORE = 2'd2,
        ACC_FILL  = 2'd3
    } acc_kind_e;
endpackage

// File: rtl/sa_way_match.sv
module sa_way_match #(
    parameter int WAYS  = 3,
    parameter int TAG_W = 5,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       any_hit,
    output logic [WAY_W-1:0]           match_way
);
    logic [WAYS-1:0] eq;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign eq[w] = way_valid[w] && (way_tag[w] == look_tag);
    end

    always_comb begin
        match_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (eq[w]) match_way = WAY_W'(w);
        end
    end

    assign any_hit = |eq;
endmodule

// File: rtl/sa_victim_pick.sv
module sa_victim_pick #(
    parameter int WAYS  = 3,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][AGE_W-1:0] way_age,
    output logic [WAY_W-1:0]           victim
);
    localparam logic [AGE_W-1:0] OLDEST = AGE_W'(WAYS - 1);

    logic [WAY_W-1:0] empty_way;
    logic [WAY_W-1:0] oldest_way;

    always_comb begin
        empty_way  = '0;
        oldest_way = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!way_valid[w])           empty_way  = WAY_W'(w);
            if (way_age[w] == OLDEST)    oldest_way = WAY_W'(w);
        end
        victim = (&way_valid) ? oldest_way : empty_way;
    end
endmodule

// File: rtl/sa_age_touch.sv
module sa_age_touch #(
    parameter int WAYS  = 3,
    parameter int AGE_W = 2,
    parameter int WAY_W = 2
) (
    input  logic [WAYS-1:0][AGE_W-1:0] age_in,
    input  logic [WAY_W-1:0]           touch_way,
    output logic [WAYS-1:0][AGE_W-1:0] age_out
);
    logic [AGE_W-1:0] touched_age;

    assign touched_age = age_in[touch_way];

    for (genvar w = 0; w < WAYS; w++) begin : g_age
        always_comb begin
            if (touch_way == WAY_W'(w))
                age_out[w] = '0;
            else if (age_in[w] < touched_age)
                age_out[w] = age_in[w] + AGE_W'(1);
            else
                age_out[w] = age_in[w];
        end
    end
endmodule

// File: rtl/sa_cache_lru.sv
module sa_cache_lru #(
    parameter int WAYS   = 3,
    parameter int SETS   = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int IDX_W  = $clog2(SETS),
    localparam int TAG_W  = ADDR_W - IDX_W,
    localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int AGE_W  = WAY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data,
    output logic              hit,
    output logic [WAY_W-1:0]  hit_way,
    output logic [DATA_W-1:0] rd_data,
    output logic [WAY_W-1:0]  victim_way,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data
);
    import sa_cache_pkg::*;

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]             valid;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0]  tag;
        logic [SETS-1:0][WAYS-1:0][DATA_W-1:0] data;
        logic [SETS-1:0][WAYS-1:0][AGE_W-1:0]  ages;
    } cache_st_t;

    cache_st_t st_d, st_q;

    logic [IDX_W-1:0]            set_idx;
    logic [TAG_W-1:0]            req_tag;
    logic [WAYS-1:0]             set_valid;
    logic [WAYS-1:0][TAG_W-1:0]  set_tag;
    logic [WAYS-1:0][AGE_W-1:0]  set_ages;
    logic [WAYS-1:0][AGE_W-1:0]  new_ages;
    logic [WAY_W-1:0]            touch_way;
    acc_kind_e                   kind;
    logic [SETS*WAYS*AGE_W-1:0]  age_flat;

    assign set_idx   = req_addr[IDX_W-1:0];
    assign req_tag   = req_addr[ADDR_W-1:IDX_W];
    assign set_valid = st_q.valid[set_idx];
    assign set_tag   = st_q.tag[set_idx];
    assign set_ages  = st_q.ages[set_idx];
    assign age_flat  = st_q.ages;

    sa_way_match #(.WAYS(WAYS), .TAG_W(TAG_W), .WAY_W(WAY_W)) match_i (
        .way_valid (set_valid),
        .way_tag   (set_tag),
        .look_tag  (req_tag),
        .any_hit   (hit),
        .match_way (hit_way)
    );

    sa_victim_pick #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) victim_i (
        .way_valid (set_valid),
        .way_age   (set_ages),
        .victim    (victim_way)
    );

    assign touch_way = hit ? hit_way : victim_way;

    sa_age_touch #(.WAYS(WAYS), .AGE_W(AGE_W), .WAY_W(WAY_W)) touch_i (
        .age_in    (set_ages),
        .touch_way (touch_way),
        .age_out   (new_ages)
    );

    assign rd_data     = hit ? st_q.data[set_idx][hit_way] : '0;
    assign mem_wr      = req_valid && req_write;
    assign mem_wr_addr = req_addr;
    assign mem_wr_data = req_wdata;

    always_comb begin
        if (!req_valid)          kind = ACC_NONE;
        else if (req_write)      kind = ACC_STORE;
        else if (hit)            kind = ACC_TOUCH;
        else if (fill_valid)     kind = ACC_FILL;
        else                     kind = ACC_NONE;
    end

    always_comb begin
        st_d = st_q;
        case (kind)
            ACC_TOUCH: begin
                st_d.ages[set_idx] = new_ages;
            end
            ACC_STORE, ACC_FILL: begin
                st_d.valid[set_idx][touch_way] = 1'b1;
                st_d.tag[set_idx][touch_way]   = req_tag;
                st_d.data[set_idx][touch_way]  = (kind == ACC_STORE) ? req_wdata : fill_data;
                st_d.ages[set_idx]             = new_ages;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.valid <= '0;
            st_q.tag   <= '0;
            st_q.data  <= '0;
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    st_q.ages[s][w] <= AGE_W'(w);
                end
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sa_cache_lru_chk.sv
module sa_cache_lru_chk #(
    parameter int WAYS   = 3,
    parameter int SETS   = 8,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int AGE_W = WAY_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic                       req_write,
    input logic [ADDR_W-1:0]          req_addr,
    input logic [DATA_W-1:0]          req_wdata,
    input logic                       fill_valid,
    input logic [DATA_W-1:0]          fill_data,
    input logic                       hit,
    input logic [WAY_W-1:0]           hit_way,
    input logic [DATA_W-1:0]          rd_data,
    input logic [WAY_W-1:0]           victim_way,
    input logic                       mem_wr,
    input logic [SETS*WAYS*AGE_W-1:0] age_flat
);
    logic perm_ok;

    always_comb begin
        perm_ok = 1'b1;
        for (int s = 0; s < SETS; s++) begin
            for (int v = 0; v < WAYS; v++) begin
                int cnt;
                cnt = 0;
                for (int w = 0; w < WAYS; w++) begin
                    if (age_flat[(s*WAYS+w)*AGE_W +: AGE_W] == AGE_W'(v)) cnt++;
                end
                if (cnt != 1) perm_ok = 1'b0;
            end
        end
    end

    AST_AGE_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        perm_ok); // R11

    AST_HIT_WAY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_way < WAY_W'(WAYS))); // R2

    AST_VICTIM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (victim_way < WAY_W'(WAYS))); // R6

    AST_READ_NO_MEMWR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |-> !mem_wr); // R10

    AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !hit && fill_valid) |=>
        (!(req_valid && !req_write && req_addr == $past(req_addr)) ||
         (hit && rd_data == $past(fill_data)))); // R4

    AST_WRITE_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=>
        (!(req_valid && !req_write && req_addr == $past(req_addr)) ||
         (hit && rd_data == $past(req_wdata)))); // R8
endmodule

bind sa_cache_lru sa_cache_lru_chk #(
    .WAYS(WAYS), .SETS(SETS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .fill_valid (fill_valid),
    .fill_data  (fill_data),
    .hit        (hit),
    .hit_way    (hit_way),
    .rd_data    (rd_data),
    .victim_way (victim_way),
    .mem_wr     (mem_wr),
    .age_flat   (age_flat)
);

// File: tb/sa_cache_lru_tb.sv
`timescale 1ns/1ps
module sa_cache_lru_tb_top;
    localparam int WAYS = 3;
    localparam int SETS = 8;
    localparam int AW   = 8;
    localparam int DW   = 16;
    localparam int IW   = 3;
    localparam int TW   = AW - IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          fill_valid = 1'b0;
    logic [DW-1:0] fill_data = '0;
    logic          hit;
    logic [1:0]    hit_way;
    logic [DW-1:0] rd_data;
    logic [1:0]    victim_way;
    logic          mem_wr;
    logic [AW-1:0] mem_wr_addr;
    logic [DW-1:0] mem_wr_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic          m_valid [SETS][WAYS];
    logic [TW-1:0] m_tag   [SETS][WAYS];
    logic [DW-1:0] m_data  [SETS][WAYS];
    int            m_age   [SETS][WAYS];

    always #2.5 clk = ~clk;

    sa_cache_lru dut_i (
        .clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata,
        .fill_valid, .fill_data, .hit, .hit_way, .rd_data, .victim_way,
        .mem_wr, .mem_wr_addr, .mem_wr_data
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic touch(input int s, input int w);
        int old = m_age[s][w];
        for (int k = 0; k < WAYS; k++) begin
            if (k == w) m_age[s][k] = 0;
            else if (m_age[s][k] < old) m_age[s][k]++;
        end
    endtask

    // One request cycle: drive, predict, compare, then advance the model
    task automatic access(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic fv, input logic [DW-1:0] fd);
        int s = int'(a[IW-1:0]);
        logic [TW-1:0] t = a[AW-1:IW];
        bit e_hit = 0;
        int e_way = 0;
        int e_vic = -1;
        bit all_valid = 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        fill_valid = fv; fill_data = fd;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (m_valid[s][w] && m_tag[s][w] == t) begin e_hit = 1; e_way = w; end
            if (!m_valid[s][w]) begin e_vic = w; all_valid = 0; end
        end
        if (all_valid)
            for (int w = 0; w < WAYS; w++) if (m_age[s][w] == WAYS - 1) e_vic = w;
        #1;
        check("R2/R3 hit", 32'(hit), 32'(e_hit));
        if (e_hit) begin
            check("R2 hit_way", 32'(hit_way), 32'(e_way));
            check("R2 rd_data", 32'(rd_data), 32'(m_data[s][e_way]));
        end else begin
            check("R2 rd_data on miss", 32'(rd_data), 32'h0);
        end
        if (all_valid) check("R6/R7 victim", 32'(victim_way), 32'(e_vic));
        else           check("R5 victim", 32'(victim_way), 32'(e_vic));
        if (wr) begin
            check("R8/R9 mem_wr", 32'(mem_wr), 32'h1);
            check("R8/R9 mem_wr_data", 32'(mem_wr_data), 32'(wd));
            check("R8/R9 mem_wr_addr", 32'(mem_wr_addr), 32'(a));
        end else begin
            check("R10 no mem_wr on read", 32'(mem_wr), 32'h0);
        end
        if (e_hit) begin
            if (wr) m_data[s][e_way] = wd;
            touch(s, e_way);
        end else if (wr || fv) begin
            m_valid[s][e_vic] = 1'b1;
            m_tag[s][e_vic]   = t;
            m_data[s][e_vic]  = wr ? wd : fd;
            touch(s, e_vic);
        end
        @(posedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 1'b0; m_tag[s][w] = '0; m_data[s][w] = '0; m_age[s][w] = w;
            end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: every set empty after reset, victim way 0, no hit
        for (int s = 0; s < SETS; s++) begin
            @(negedge clk);
            req_valid = 1'b1; req_write = 1'b0; req_addr = AW'({5'd7, 3'(s)}); fill_valid = 1'b0;
            #1;
            check("R1 reset miss", 32'(hit), 32'h0);
            check("R1 reset victim", 32'(victim_way), 32'h0);
        end

        // R4/R5: fill each set through its empty ways, same tags in every set (R3)
        for (int s = 0; s < SETS; s++)
            for (int t = 1; t <= WAYS; t++) begin
                access(1'b0, AW'({5'(t), 3'(s)}), '0, 1'b1, DW'(16'h1000 + s*16 + t));
                access(1'b0, AW'({5'(t), 3'(s)}), '0, 1'b0, '0);
            end

        // R7: in set 0 ways hold tags 1,2,3; reading tag 1 makes way 1 the oldest
        access(1'b0, AW'({5'd1, 3'd0}), '0, 1'b0, '0);
        @(negedge clk);
        req_addr = AW'({5'd9, 3'd0}); req_write = 1'b0; fill_valid = 1'b0;
        #1 check("R7 victim after touching way 0", 32'(victim_way), 32'h1);
        // R10: fill strobe during a hit is ignored
        access(1'b0, AW'({5'd2, 3'd0}), '0, 1'b1, 16'hDEAD);
        access(1'b0, AW'({5'd2, 3'd0}), '0, 1'b0, '0);
        // R9: write miss allocates; R8: write hit updates
        access(1'b1, AW'({5'd20, 3'd0}), 16'h5A5A, 1'b0, '0);
        access(1'b1, AW'({5'd20, 3'd0}), 16'hA5A5, 1'b0, '0);
        access(1'b0, AW'({5'd20, 3'd0}), '0, 1'b0, '0);

        // Long conflict-heavy stream over all sets, five tags per set
        for (int i = 0; i < 4000; i++) begin
            logic wr, fv;
            logic [AW-1:0] a;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a  = AW'({5'(int'(lfsr[15:8]) % 5), lfsr[2:0]});
            wr = (lfsr[5:4] == 2'b00);
            fv = (lfsr[7:6] != 2'b00);
            access(wr, a, lfsr ^ 16'h3C3C, fv, {lfsr[7:0], lfsr[15:8]});
        end

        @(negedge clk);
        req_valid = 1'b0; fill_valid = 1'b0;
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule